// File: doc/BRIEF.md
# Interlocked Parallel-Bus Host Cycle Engine

This block is the host side of an interlocked parallel-port exchange. A single request turns into one complete, peripheral-paced handshake on an 8-bit bus. There are four kinds of request: data write, data read, address write and address read. Each exchange drives a write-direction line, a data strobe or an address strobe, all active low, and watches the peripheral's active-low wait line. The peripheral stretches each exchange for as long as it needs by holding wait low. It then raises wait to say the byte has been taken or supplied.

Requests arrive on a valid/ready port. A data request can be marked wide, and then it runs as a burst of byte exchanges over ascending byte lanes. Every byte exchange has a clock budget. If the peripheral does not answer in time, the exchange is abandoned, the lines are released and the result carries a timeout flag.

In standard mode the engine asserts a strobe only after it has seen wait low. A legacy-mode input removes that gate. The wait input is assumed to be already synchronous to `clk`.

Top module: `epp_host_engine`

## Requirements
- R1: While reset is active and on the first cycle after it, both strobes and `write_n` are high, `bus_oe` is 0, `busy` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: `req_ready` is high only while the engine is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_kind` bit 0 = 1 means read and bit 1 = 1 means address. `busy` is high from the cycle after acceptance up to the cycle in which `rsp_valid` pulses, and it is low in that cycle.
- R3: Data exchanges drive only `dstb_n` low. Address exchanges drive only `astb_n` low.
- R4: In a write exchange, `write_n` is low and `bus_oe` is high with the current byte on `bus_out` from the first cycle of the exchange. This is at least one cycle before the strobe falls, and the lines hold until the strobe rises.
- R5: In a read exchange, `write_n` stays high and `bus_oe` stays low. `bus_in` is captured on the clock edge at which wait is first sampled high while the strobe is low.
- R6: In standard mode (`legacy_mode` = 0), a strobe falls only after a clock edge at which `wait_n` was sampled low. While `wait_n` stays high, no strobe is asserted.
- R7: In legacy mode, the strobe falls in the second cycle of every byte exchange, whatever the level of `wait_n`.
- R8: The strobe rises in the cycle after `wait_n` is sampled high. When the last byte finishes, `rsp_valid` pulses for exactly one cycle with `rsp_timeout` = 0.
- R9: Each byte exchange has `TMO_CYCLES` clock cycles, counted from its first cycle. If it has not finished by the last of them, the next cycle has both strobes high, `write_n` high, `bus_oe` low and `rsp_valid` with `rsp_timeout` = 1. If wait is sampled high in the last allowed cycle, the exchange completes normally.
- R10: A wide data request runs four byte exchanges, lanes 0 to 3 in order. Lane i is bits [8i+7:8i] of `req_wdata` and of `rsp_rdata`. Address requests ignore `req_wide` and use lane 0 only. Lanes that were not read, and all lanes after a write, return 0 in `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | 1: strobe is not gated by wait |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, can take a request |
| req_kind | input | 2 | Bit 0 read, bit 1 address |
| req_wide | input | 1 | Four-byte data burst |
| req_wdata | input | 32 | Write bytes, lane 0 in the low bits |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Completion was an abort |
| rsp_rdata | output | 32 | Read bytes by lane |
| busy | output | 1 | Exchange in progress |
| bus_out | output | 8 | Byte driven to the bus |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | 8 | Byte sampled from the bus |
| write_n | output | 1 | Low during write exchanges |
| dstb_n | output | 1 | Data strobe, active low |
| astb_n | output | 1 | Address strobe, active low |
| wait_n | input | 1 | Peripheral wait, high means answered |

## Verification
The peripheral's answer and the expiry of the timeout budget can land on the same clock edge. When they do, the answer must win. The bench provokes this with a model peripheral that delays its wait rise so that the rise arrives exactly in the last permitted cycle, and then one cycle later. It expects a clean completion in the first case and an abort in the second. A held-high wait in standard mode is used the same way to make the budget run out before any strobe has been asserted.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } eng_state_t;

  typedef struct packed {
    logic is_addr;
    logic is_read;
  } xfer_kind_t;
endpackage

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (restart)                  cnt_q <= '0;
    else if (run && (cnt_q != LAST))   cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);

  AST_TMO_CAP: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LAST) else $error("timer overran"); // R9
endmodule

// File: rtl/epp_lane_unit.sv
module epp_lane_unit #(
  parameter int BYTES = 4,
  parameter int IDX_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [8*BYTES-1:0] load_data,
  input  logic [IDX_W-1:0]   idx,
  input  logic               cap,
  input  logic [7:0]         cap_byte,
  output logic [7:0]         wr_byte,
  output logic [8*BYTES-1:0] rdata
);
  logic [8*BYTES-1:0] wd_q;
  logic [7:0]         rd_q [BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wd_q <= '0;
    else if (load) wd_q <= load_data;
  end

  assign wr_byte = wd_q[8*idx +: 8];

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             rd_q[i] <= '0;
      else if (load)                          rd_q[i] <= '0;
      else if (cap && (idx == IDX_W'(i)))     rd_q[i] <= cap_byte;
    end
    assign rdata[8*i +: 8] = rd_q[i];
  end
endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
  import epp_pkg::*;
#(
  parameter int BYTES      = 4,
  parameter int TMO_CYCLES = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               legacy_mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic               req_wide,
  input  logic [8*BYTES-1:0] req_wdata,
  output logic               rsp_valid,
  output logic               rsp_timeout,
  output logic [8*BYTES-1:0] rsp_rdata,
  output logic               busy,
  output logic [7:0]         bus_out,
  output logic               bus_oe,
  input  logic [7:0]         bus_in,
  output logic               write_n,
  output logic               dstb_n,
  output logic               astb_n,
  input  logic               wait_n
);
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

  eng_state_t       state_q;
  xfer_kind_t       kind_q;
  logic             wide_q;
  logic [IDX_W-1:0] idx_q;
  logic             rsp_valid_q, rsp_tmo_q;

  logic active, accept, go_strobe, ack, last_byte, expired, tmo_abort;

  assign active    = (state_q != ST_IDLE);
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign go_strobe = (state_q == ST_SETUP) && (legacy_mode || !wait_n);
  assign ack       = (state_q == ST_STROBE) && wait_n;
  assign last_byte = !wide_q || kind_q.is_addr || (idx_q == LAST_IDX);
  assign tmo_abort = expired && ((state_q == ST_SETUP) || ((state_q == ST_STROBE) && !wait_n));

  epp_wait_timer #(.LIMIT(TMO_CYCLES)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept || (ack && !last_byte)),
    .run     (active),
    .expired (expired)
  );

  epp_lane_unit #(.BYTES(BYTES), .IDX_W(IDX_W)) i_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (req_wdata),
    .idx       (idx_q),
    .cap       (ack && kind_q.is_read),
    .cap_byte  (bus_in),
    .wr_byte   (bus_out),
    .rdata     (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      kind_q      <= '0;
      wide_q      <= 1'b0;
      idx_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_tmo_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_SETUP;
            kind_q  <= xfer_kind_t'(req_kind);
            wide_q  <= req_wide;
            idx_q   <= '0;
          end
        end
        ST_SETUP: begin
          if (tmo_abort) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_tmo_q   <= 1'b1;
          end else if (go_strobe) begin
            state_q <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (ack) begin
            if (last_byte) begin
              state_q     <= ST_IDLE;
              rsp_valid_q <= 1'b1;
              rsp_tmo_q   <= 1'b0;
            end else begin
              state_q <= ST_SETUP;
              idx_q   <= idx_q + 1'b1;
            end
          end else if (tmo_abort) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_tmo_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = !active;
  assign busy        = active;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_timeout = rsp_tmo_q;
  assign bus_oe      = active && !kind_q.is_read;
  assign write_n     = !bus_oe;
  assign dstb_n      = !((state_q == ST_STROBE) && !kind_q.is_addr);
  assign astb_n      = !((state_q == ST_STROBE) && kind_q.is_addr);

  AST_STB_WAIT_GATED: assert property (@(posedge clk) disable iff (!rst_n) ($fell(dstb_n && astb_n) && !$past(legacy_mode)) |-> !$past(wait_n)) else $error("strobe not gated"); // R6
  AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rst_n) ($fell(dstb_n && astb_n) && !write_n) |-> $past(!write_n && bus_oe)) else $error("write setup missing"); // R4
  AST_STB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) ($past(!(dstb_n && astb_n)) && $past(wait_n)) |-> (dstb_n && astb_n)) else $error("strobe held after answer"); // R8
  AST_TMO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_timeout) |-> (dstb_n && astb_n && write_n && !bus_oe)) else $error("lines not released on abort"); // R9
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || rsp_valid)) else $error("busy dropped early"); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid) else $error("response pulse too long"); // R8
endmodule

// File: tb/test_epp_host_engine.sv
`timescale 1ns/1ps
module test_epp_host_engine;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        legacy_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b00;
  logic        req_wide = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_timeout, busy;
  logic [31:0] rsp_rdata;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [7:0]  bus_in = '0;
  logic        write_n, dstb_n, astb_n;
  logic        wait_n = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit          got_rsp, got_tmo, got_busy;
  logic [31:0] got_rd;
  logic [3:0]  got_lines;

  always #2.5 clk = ~clk;

  epp_host_engine #(.BYTES(4), .TMO_CYCLES(TMO)) i_epp_host_engine (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_wide(req_wide), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
    .busy(busy), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .write_n(write_n), .dstb_n(dstb_n), .astb_n(astb_n), .wait_n(wait_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rsp_valid) begin
      got_rsp   = 1;
      got_tmo   = rsp_timeout;
      got_rd    = rsp_rdata;
      got_busy  = busy;
      got_lines = {dstb_n, astb_n, write_n, bus_oe};
    end
  endtask

  function automatic bit exp_timeout(input bit leg, input int hold, input int dly);
    if (leg) return (hold == 0) && (dly >= TMO - 1);
    return (hold + dly) >= (TMO - 1);
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [1:0] kind, input int nb,
                                            input logic [31:0] rd);
    logic [31:0] r = '0;
    if (kind[0]) for (int b = 0; b < nb; b++) r[8*b +: 8] = rd[8*b +: 8];
    return r;
  endfunction

  task automatic run_txn(input logic [1:0] kind, input logic wide, input logic [31:0] wd,
                         input logic [31:0] rd, input bit leg, input int hold, input int dly);
    int nb;
    int guard;
    bit et;
    logic [31:0] er;
    nb = (wide && !kind[1]) ? 4 : 1;
    et = exp_timeout(leg, hold, dly);
    er = exp_rdata(kind, nb, rd);
    got_rsp = 0;
    @(negedge clk);
    legacy_mode = leg; req_kind = kind; req_wide = wide; req_wdata = wd; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2", "ready while idle", {31'b0, req_ready}, 1);
    step();
    req_valid = 1'b0;
    chk(busy && !req_ready, "R2", "busy/ready after accept", {30'b0, busy, req_ready}, 2);
    for (int b = 0; b < nb && !got_rsp; b++) begin
      wait_n = (hold > 0);
      bus_in = rd[8*b +: 8];
      if (!kind[0])
        chk(!write_n && bus_oe && bus_out == wd[8*b +: 8] && dstb_n && astb_n, "R4",
            "write setup before strobe", {22'b0, write_n, bus_oe, bus_out}, {24'h1, wd[8*b +: 8]});
      else
        chk(write_n && !bus_oe, "R5", "read leaves bus released", {30'b0, write_n, bus_oe}, 2);
      if (!leg) begin
        for (int h = 0; h < hold && !got_rsp; h++) begin
          step();
          chk(dstb_n && astb_n, "R6", "no strobe while wait high", {30'b0, dstb_n, astb_n}, 3);
        end
        wait_n = 1'b0;
      end
      guard = 0;
      while (dstb_n && astb_n && !got_rsp && guard < 4*TMO) begin
        step();
        guard++;
      end
      if (!got_rsp) begin
        chk(kind[1] ? (dstb_n && !astb_n) : (!dstb_n && astb_n), "R3", "strobe choice",
            {30'b0, dstb_n, astb_n}, kind[1] ? 2 : 1);
        chk(guard == 1, leg ? "R7" : "R6", "strobe delay after gate", guard, 1);
        if (!kind[0])
          chk(!write_n && bus_out == wd[8*b +: 8], "R10", "lane byte on bus", bus_out, wd[8*b +: 8]);
        else
          chk(write_n && !bus_oe, "R5", "read strobe with bus released", {30'b0, write_n, bus_oe}, 2);
        if (!wait_n) for (int d = 0; d < dly && !got_rsp; d++) step();
        if (!got_rsp) begin
          wait_n = 1'b1;
          step();
          chk(dstb_n && astb_n, "R8", "strobe released after answer", {30'b0, dstb_n, astb_n}, 3);
        end
      end
    end
    guard = 0;
    while (!got_rsp && guard < 4*TMO) begin
      step();
      guard++;
    end
    chk(got_rsp, "R8", "response seen", {31'b0, got_rsp}, 1);
    chk(got_tmo == et, et ? "R9" : "R8", "timeout flag", {31'b0, got_tmo}, {31'b0, et});
    chk(got_lines == 4'b1110, "R9", "lines idle at response", {28'b0, got_lines}, 32'he);
    chk(!got_busy, "R2", "busy low with response", {31'b0, got_busy}, 0);
    if (!et) chk(got_rd == er, kind[0] ? "R5" : "R10", "read data lanes", got_rd, er);
    wait_n = 1'b0;
    step();
    chk(!rsp_valid, "R8", "single-cycle response", {31'b0, rsp_valid}, 0);
  endtask

  initial begin
    void'($urandom(32'd1284));
    repeat (3) @(negedge clk);
    chk(dstb_n && astb_n && write_n && !bus_oe && !busy && !rsp_valid && req_ready, "R1",
        "reset state", {25'b0, dstb_n, astb_n, write_n, bus_oe, busy, rsp_valid, req_ready}, 32'h71);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dstb_n && astb_n && write_n && !bus_oe && !busy && req_ready, "R1",
        "first cycle after reset", {26'b0, dstb_n, astb_n, write_n, bus_oe, busy, req_ready}, 32'h39);

    run_txn(2'b00, 1'b0, 32'h0000_005A, 32'h0,         1'b0, 0, 2);
    run_txn(2'b01, 1'b0, 32'h0,         32'h0000_00C3, 1'b0, 1, 0);
    run_txn(2'b10, 1'b1, 32'hDEAD_BE11, 32'h0,         1'b0, 0, 1);
    run_txn(2'b11, 1'b1, 32'h0,         32'hA1B2_C3D4, 1'b0, 0, 1);
    run_txn(2'b01, 1'b1, 32'h0,         32'h1122_3344, 1'b0, 2, 3);
    run_txn(2'b00, 1'b1, 32'h5566_7788, 32'h0,         1'b1, 0, 2);
    run_txn(2'b01, 1'b0, 32'h0,         32'h0000_0077, 1'b0, 0, TMO - 2);
    run_txn(2'b01, 1'b0, 32'h0,         32'h0000_0077, 1'b0, 0, TMO - 1);
    run_txn(2'b00, 1'b0, 32'h0000_0099, 32'h0,         1'b0, TMO + 4, 0);
    run_txn(2'b10, 1'b0, 32'h0000_0042, 32'h0,         1'b1, 3, 0);
    run_txn(2'b11, 1'b0, 32'h0,         32'h0000_00E7, 1'b1, 0, TMO - 1);
    run_txn(2'b00, 1'b1, 32'hCAFE_F00D, 32'h0,         1'b0, 0, TMO);

    for (int n = 0; n < 60; n++) begin
      run_txn(2'($urandom % 4), 1'($urandom % 2), $urandom, $urandom,
              1'($urandom % 2), int'($urandom % 4), int'($urandom % 6));
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5ns * 200000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not end actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule